// File: doc/BRIEF.md
# Double-Precision to Signed Word Converter

This block turns a 64-bit IEEE-754 double-precision operand into a signed 32-bit integer. It rounds the value under one of four selectable rounding modes and clamps out-of-range operands. It reports whether the conversion was invalid, whether the result is inexact, and whether rounding moved the result away from zero. A force-truncate control selects rounding toward zero whatever the mode field holds, which serves the always-truncating form of the operation. The integer is returned inside a fixed 64-bit register image. When the record control is set, the block also passes a 4-bit condition field through from status inputs supplied to it.

The conversion logic is combinational: an unpack stage extracts the integer part and the rounding bits, and a rounding stage applies the mode and the clamping. A single register stage follows. A two-state controller tracks result validity. `ST_IDLE` moves to `ST_EMIT` when `in_valid` is high. `ST_EMIT` stays in `ST_EMIT` while further operands arrive and returns to `ST_IDLE` when none arrives. Result registers load only on an accepted operand and hold their value otherwise.

Top module: `d2i_conv`

## Requirements
- R1: A result appears with `out_valid` high exactly one clock after `in_valid` is sampled high. `out_valid` is low in every other cycle. All result outputs hold their values while no operand is accepted.
- R2: An operand greater than 2147483647, including +infinity, yields low word 0x7FFFFFFF with `out_invalid`=1 and `out_fi`=`out_fr`=0.
- R3: An operand less than -2147483648, including -infinity, or any NaN of either sign, yields low word 0x80000000 with `out_invalid`=1 and `out_fi`=`out_fr`=0. -2147483648 itself converts without being invalid.
- R4: Mode code 2'b00 rounds to the nearest integer, and an exact tie goes toward zero (2.5 gives 2, -2.5 gives -2, 2.7 gives 3).
- R5: Mode code 2'b01 truncates toward zero. When `in_trunc` is high, truncation is used for every mode code.
- R6: Mode code 2'b10 rounds toward +infinity. Mode code 2'b11 rounds toward -infinity.
- R7: When the in-range result equals the operand, `out_fi`=0 and `out_fr`=0. Otherwise `out_fi`=1, and `out_fr`=1 only if the result's magnitude exceeds the operand's.
- R8: `out_word[63:32]` is 0xFFF80000, with bit 32 also set when the integer result is zero and the operand's sign bit is 1. `out_word[31:0]` holds the two's-complement integer.
- R9: With `in_rec` high, `out_cr_wr`=1 and `out_cr`={`in_fx`,`in_fex`,`in_vx`,`in_ox`}, with `in_fx` at bit 3. With `in_rec` low, both are 0.
- R10: Zero and subnormal operands give integer 0 in modes 00 and 01. A nonzero subnormal is inexact and can round to +1 or -1 under the directed modes. A zero is exact.
- R11: Reset clears `out_valid`, `out_word`, and all flag and condition outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_op | input | 64 | Double-precision operand |
| in_rmode | input | 2 | Rounding mode code |
| in_trunc | input | 1 | Force round toward zero |
| in_rec | input | 1 | Record control for the condition field |
| in_fx | input | 1 | Status input, condition bit 3 |
| in_fex | input | 1 | Status input, condition bit 2 |
| in_vx | input | 1 | Status input, condition bit 1 |
| in_ox | input | 1 | Status input, condition bit 0 |
| out_valid | output | 1 | Result valid |
| out_word | output | 64 | Result register image |
| out_invalid | output | 1 | Invalid conversion |
| out_fi | output | 1 | Result inexact |
| out_fr | output | 1 | Rounded away from zero in magnitude |
| out_cr_wr | output | 1 | Condition field is being written |
| out_cr | output | 4 | Condition field value |

## Verification
Operands with fractions just below, at, and just above one half are run through every mode code. These separate tie handling from ordinary nearest rounding and show which direction each directed mode moves, for both signs. Values on each side of both clamping limits, together with infinities and NaNs, check that clamping is decided from the operand and not from the rounded result. Signed zeros, small negative fractions and subnormals check the negative-zero marker and the inexact flag at the low end. A scoreboard compares each result with a model built on the host's real arithmetic.

// File: rtl/d2i_pkg.sv
package d2i_pkg;
    localparam int EXP_W  = 11;
    localparam int MAN_W  = 52;
    localparam int OP_W   = 1 + EXP_W + MAN_W;
    localparam int INT_W  = 32;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int MW     = MAN_W + 1;
    localparam int SH_W   = $clog2(MW + 1);
    localparam logic [INT_W-1:0] RES_HI = 32'hFFF8_0000;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_PINF = 2'b10,
        RM_NINF = 2'b11
    } rmode_e;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             big;
        logic [INT_W-1:0] ipart;
        logic             half;
        logic             sticky;
    } split_t;
endpackage

// File: rtl/d2i_split.sv
module d2i_split
    import d2i_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output split_t          sp
);
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] fr;
    logic [MW-1:0]    mant;
    logic [MW-1:0]    hbit;
    logic [MW-1:0]    below;
    logic [SH_W-1:0]  shamt;
    int               e_unb;

    assign ex    = op[OP_W-2 -: EXP_W];
    assign fr    = op[MAN_W-1:0];
    assign mant  = {(ex != '0), fr};
    assign e_unb = int'(ex) - BIAS;

    always_comb begin
        sp       = '0;
        sp.sign  = op[OP_W-1];
        shamt    = '0;
        hbit     = '0;
        below    = '0;
        if (ex == '1) begin
            sp.nan = (fr != '0);
            sp.big = 1'b1;
        end else if (e_unb >= INT_W) begin
            sp.big = 1'b1;
        end else if (e_unb >= 0) begin
            shamt     = SH_W'(MAN_W - e_unb);
            hbit      = MW'(1) << (shamt - SH_W'(1));
            below     = hbit - MW'(1);
            sp.ipart  = INT_W'(mant >> shamt);
            sp.half   = |(mant & hbit);
            sp.sticky = |(mant & below);
        end else if (e_unb == -1) begin
            sp.half   = 1'b1;
            sp.sticky = (fr != '0);
        end else begin
            sp.sticky = (mant != '0);
        end
    end
endmodule

// File: rtl/d2i_round.sv
module d2i_round
    import d2i_pkg::*;
(
    input  split_t           sp,
    input  rmode_e           mode,
    output logic [INT_W-1:0] value,
    output logic             invalid,
    output logic             fi,
    output logic             fr,
    output logic             negz
);
    localparam logic [INT_W-1:0] MAX_POS = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] MIN_NEG = {1'b1, {(INT_W-1){1'b0}}};

    logic             frac_nz;
    logic             pos_ovf;
    logic             neg_ovf;
    logic             inc;
    logic [INT_W-1:0] mag;

    assign frac_nz = sp.half | sp.sticky;
    assign pos_ovf = !sp.sign && !sp.nan &&
                     (sp.big || (sp.ipart > MAX_POS) || ((sp.ipart == MAX_POS) && frac_nz));
    assign neg_ovf = sp.nan || (sp.sign &&
                     (sp.big || (sp.ipart > MIN_NEG) || ((sp.ipart == MIN_NEG) && frac_nz)));

    always_comb begin
        unique case (mode)
            RM_NEAR: inc = sp.half && sp.sticky;
            RM_ZERO: inc = 1'b0;
            RM_PINF: inc = frac_nz && !sp.sign;
            RM_NINF: inc = frac_nz && sp.sign;
        endcase
    end

    assign mag = sp.ipart + INT_W'(inc);

    always_comb begin
        value   = sp.sign ? (~mag + INT_W'(1)) : mag;
        invalid = 1'b0;
        fi      = frac_nz;
        fr      = inc;
        if (pos_ovf) begin
            value   = MAX_POS;
            invalid = 1'b1;
            fi      = 1'b0;
            fr      = 1'b0;
        end else if (neg_ovf) begin
            value   = MIN_NEG;
            invalid = 1'b1;
            fi      = 1'b0;
            fr      = 1'b0;
        end
        negz = !invalid && (value == '0) && sp.sign;
    end
endmodule

// File: rtl/d2i_conv.sv
module d2i_conv
    import d2i_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OP_W-1:0] in_op,
    input  logic [1:0]      in_rmode,
    input  logic            in_trunc,
    input  logic            in_rec,
    input  logic            in_fx,
    input  logic            in_fex,
    input  logic            in_vx,
    input  logic            in_ox,
    output logic            out_valid,
    output logic [63:0]     out_word,
    output logic            out_invalid,
    output logic            out_fi,
    output logic            out_fr,
    output logic            out_cr_wr,
    output logic [3:0]      out_cr
);
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } st_e;

    st_e              state_q;
    st_e              state_d;
    split_t           sp;
    rmode_e           eff_mode;
    logic [INT_W-1:0] r_value;
    logic             r_invalid;
    logic             r_fi;
    logic             r_fr;
    logic             r_negz;

    assign eff_mode = in_trunc ? RM_ZERO : rmode_e'(in_rmode);

    d2i_split u_split (
        .op (in_op),
        .sp (sp)
    );

    d2i_round u_round (
        .sp      (sp),
        .mode    (eff_mode),
        .value   (r_value),
        .invalid (r_invalid),
        .fi      (r_fi),
        .fr      (r_fr),
        .negz    (r_negz)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word    <= '0;
            out_invalid <= 1'b0;
            out_fi      <= 1'b0;
            out_fr      <= 1'b0;
            out_cr_wr   <= 1'b0;
            out_cr      <= '0;
        end else if (in_valid) begin
            out_word    <= {RES_HI | {{(INT_W-1){1'b0}}, r_negz}, r_value};
            out_invalid <= r_invalid;
            out_fi      <= r_fi;
            out_fr      <= r_fr;
            out_cr_wr   <= in_rec;
            out_cr      <= in_rec ? {in_fx, in_fex, in_vx, in_ox} : 4'b0000;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/d2i_conv_chk.sv
module d2i_conv_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_trunc,
    input logic        in_rec,
    input logic        in_fx,
    input logic        in_fex,
    input logic        in_vx,
    input logic        in_ox,
    input logic        out_valid,
    input logic [63:0] out_word,
    input logic        out_invalid,
    input logic        out_fi,
    input logic        out_fr,
    input logic        out_cr_wr,
    input logic [3:0]  out_cr
);
    // R1
    lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word));

    // R8
    prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_word[63:32] & ~32'h1) == 32'hFFF8_0000));

    // R8
    negz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_word[32] |-> (out_word[31:0] == 32'h0));

    // R7
    fr_fi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_fr |-> out_fi);

    // R2
    sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> (!out_fi && !out_fr &&
            (out_word[31:0] == 32'h7FFF_FFFF || out_word[31:0] == 32'h8000_0000)));

    // R5
    trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_trunc) |=> !out_fr);

    // R9
    cr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_rec) |=> (out_cr_wr && out_cr == $past({in_fx, in_fex, in_vx, in_ox})));

    // R9
    cr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_cr_wr |-> (out_cr == 4'b0000));
endmodule

bind d2i_conv d2i_conv_chk u_chk (.*);

// File: tb/tb_d2i_conv.sv
`timescale 1ns/1ps
module tb_d2i_conv;
    typedef struct packed {
        logic [63:0] word;
        logic        inv;
        logic        fi;
        logic        fr;
        logic        crw;
        logic [3:0]  cr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_op = '0;
    logic [1:0]  in_rmode = '0;
    logic        in_trunc = 1'b0;
    logic        in_rec = 1'b0;
    logic        in_fx = 1'b0, in_fex = 1'b0, in_vx = 1'b0, in_ox = 1'b0;
    logic        out_valid;
    logic [63:0] out_word;
    logic        out_invalid, out_fi, out_fr, out_cr_wr;
    logic [3:0]  out_cr;

    int    n_chk = 0;
    int    n_bad = 0;
    exp_t  exp_q[$];
    string tag_q[$];
    logic [63:0] last_word = '0;
    bit    done = 0;

    always #4 clk = ~clk;

    d2i_conv dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_rmode(in_rmode), .in_trunc(in_trunc), .in_rec(in_rec),
        .in_fx(in_fx), .in_fex(in_fex), .in_vx(in_vx), .in_ox(in_ox),
        .out_valid(out_valid), .out_word(out_word), .out_invalid(out_invalid),
        .out_fi(out_fi), .out_fr(out_fr), .out_cr_wr(out_cr_wr), .out_cr(out_cr)
    );

    function automatic exp_t model(input logic [63:0] op, input logic [1:0] rm,
                                   input logic tr, input logic rec, input logic [3:0] fl);
        exp_t   e;
        real    b;
        real    frc;
        longint t;
        longint i;
        logic [1:0] m;
        logic   nan;
        e   = '0;
        b   = $bitstoreal(op);
        m   = tr ? 2'b01 : rm;
        nan = (op[62:52] == 11'h7FF) && (op[51:0] != '0);
        if (nan || b < -2147483648.0) begin
            e.word[31:0] = 32'h8000_0000;
            e.inv = 1'b1;
        end else if (b > 2147483647.0) begin
            e.word[31:0] = 32'h7FFF_FFFF;
            e.inv = 1'b1;
        end else begin
            t   = longint'($rtoi(b));
            frc = b - real'(t);
            i   = t;
            case (m)
                2'b00: begin
                    if (frc > 0.5) i = t + 1;
                    else if (frc < -0.5) i = t - 1;
                end
                2'b10: if (frc > 0.0) i = t + 1;
                2'b11: if (frc < 0.0) i = t - 1;
                default: i = t;
            endcase
            e.word[31:0] = i[31:0];
            e.fi = (frc != 0.0);
            e.fr = (i != t);
        end
        e.word[63:32] = 32'hFFF8_0000;
        if (e.word[31:0] == 32'h0 && op[63]) e.word[32] = 1'b1;
        e.crw = rec;
        e.cr  = rec ? fl : 4'b0000;
        return e;
    endfunction

    task automatic issue(input logic [63:0] op, input logic [1:0] rm, input logic tr,
                         input logic rec, input logic [3:0] fl, input string tag);
        exp_q.push_back(model(op, rm, tr, rec, fl));
        tag_q.push_back(tag);
        @(negedge clk);
        in_op = op; in_rmode = rm; in_trunc = tr; in_rec = rec;
        {in_fx, in_fex, in_vx, in_ox} = fl;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic issue_r(input real v, input logic [1:0] rm, input logic tr, input string tag);
        issue($realtobits(v), rm, tr, 1'b0, 4'b0000, tag);
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t  e;
            string tg;
            exp_t  got;
            got = '{word: out_word, inv: out_invalid, fi: out_fi, fr: out_fr,
                    crw: out_cr_wr, cr: out_cr};
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R1 unexpected result: actual %h expected none", out_word);
            end else begin
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                if (got !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual word=%h inv=%b fi=%b fr=%b crw=%b cr=%b expected word=%h inv=%b fi=%b fr=%b crw=%b cr=%b",
                             tg, got.word, got.inv, got.fi, got.fr, got.crw, got.cr,
                             e.word, e.inv, e.fi, e.fr, e.crw, e.cr);
                end
            end
            last_word = out_word;
        end
    end

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        n_chk++;
        if (out_valid !== 1'b0 || out_word !== 64'h0 || out_invalid !== 1'b0 ||
            out_fi !== 1'b0 || out_fr !== 1'b0 || out_cr_wr !== 1'b0 || out_cr !== 4'h0) begin
            n_bad++;
            $display("FAIL R11: actual valid=%b word=%h expected valid=0 word=0", out_valid, out_word);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R4 nearest, ties toward zero
        issue_r(2.5, 2'b00, 1'b0, "R4 2.5");
        issue_r(-2.5, 2'b00, 1'b0, "R4 -2.5");
        issue_r(2.7, 2'b00, 1'b0, "R4 2.7");
        issue_r(-2.7, 2'b00, 1'b0, "R4 -2.7");
        issue_r(0.5, 2'b00, 1'b0, "R4 0.5");
        issue_r(3.5, 2'b00, 1'b0, "R4 3.5");
        issue_r(2.2, 2'b00, 1'b0, "R4 2.2");
        issue_r(2147483646.5, 2'b00, 1'b0, "R4 tie near max");
        // R5 truncation and forced truncation
        issue_r(2.7, 2'b01, 1'b0, "R5 2.7");
        issue_r(-2.7, 2'b01, 1'b0, "R5 -2.7");
        issue_r(2.7, 2'b10, 1'b1, "R5 forced over +inf mode");
        issue_r(-2.7, 2'b11, 1'b1, "R5 forced over -inf mode");
        issue_r(2.7, 2'b00, 1'b1, "R5 forced over nearest");
        // R6 directed modes
        issue_r(2.2, 2'b10, 1'b0, "R6 +inf 2.2");
        issue_r(-2.2, 2'b10, 1'b0, "R6 +inf -2.2");
        issue_r(2.2, 2'b11, 1'b0, "R6 -inf 2.2");
        issue_r(-2.2, 2'b11, 1'b0, "R6 -inf -2.2");
        issue_r(-2147483647.5, 2'b11, 1'b0, "R6 -inf to min");
        // R7 exact and inexact flags
        for (int m = 0; m < 4; m++) issue_r(3.0, 2'(m), 1'b0, "R7 exact 3.0");
        issue_r(1000000.25, 2'b10, 1'b0, "R7 inexact up");
        issue_r(1000000.25, 2'b00, 1'b0, "R7 inexact down");
        // R2 positive clamp
        issue_r(2147483647.0, 2'b00, 1'b0, "R2 max exact");
        issue_r(2147483647.5, 2'b01, 1'b0, "R2 just above max");
        issue_r(2147483648.0, 2'b10, 1'b0, "R2 2^31");
        issue_r(1.0e10, 2'b00, 1'b0, "R2 1e10");
        issue(64'h7FF0_0000_0000_0000, 2'b00, 1'b0, 1'b0, 4'h0, "R2 +inf");
        // R3 negative clamp and NaN
        issue_r(-2147483648.0, 2'b00, 1'b0, "R3 min exact");
        issue_r(-2147483648.5, 2'b10, 1'b0, "R3 just below min");
        issue(64'hFFF0_0000_0000_0000, 2'b00, 1'b0, 1'b0, 4'h0, "R3 -inf");
        issue(64'h7FF8_0000_0000_0000, 2'b00, 1'b0, 1'b0, 4'h0, "R3 NaN");
        issue(64'hFFF0_0000_0000_0001, 2'b10, 1'b0, 1'b0, 4'h0, "R3 neg NaN");
        // R8 negative-zero marker
        issue_r(-0.3, 2'b01, 1'b0, "R8 -0.3 trunc");
        issue(64'h8000_0000_0000_0000, 2'b00, 1'b0, 1'b0, 4'h0, "R8 -0.0");
        issue(64'h0, 2'b00, 1'b0, 1'b0, 4'h0, "R8 +0.0");
        issue_r(-0.7, 2'b10, 1'b0, "R8 -0.7 up");
        // R10 subnormals
        issue(64'h0000_0000_0000_0001, 2'b00, 1'b0, 1'b0, 4'h0, "R10 subnormal near");
        issue(64'h0000_0000_0000_0001, 2'b10, 1'b0, 1'b0, 4'h0, "R10 subnormal up");
        issue(64'h8000_0000_0000_0001, 2'b11, 1'b0, 1'b0, 4'h0, "R10 neg subnormal down");
        issue(64'h000F_FFFF_FFFF_FFFF, 2'b01, 1'b0, 1'b0, 4'h0, "R10 subnormal trunc");
        // R9 condition field
        issue($realtobits(5.5), 2'b00, 1'b0, 1'b1, 4'b1010, "R9 rec 1010");
        issue($realtobits(-7.0), 2'b01, 1'b0, 1'b1, 4'b0101, "R9 rec 0101");
        issue($realtobits(1.0), 2'b00, 1'b0, 1'b0, 4'b1111, "R9 no rec");

        // R1 outputs hold while idle
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_word !== last_word) begin
            n_bad++;
            $display("FAIL R1 hold: actual valid=%b word=%h expected valid=0 word=%h",
                     out_valid, out_word, last_word);
        end
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R1 missing results: actual %0d pending expected 0", exp_q.size());
        end
        done = 1;
        summary();
    end
endmodule